// File: doc/BRIEF.md
# Character Display Controller Host Register Interface

This block is the side of a dot-matrix character display controller that a microprocessor talks to. Each host access is one clock of the `host_en` strobe. `host_rs` picks the command side or the data side, and `host_rd` picks a read or a write. A command write lands in a write-only instruction register and starts an internal operation. A command read returns the busy flag together with the 7-bit address counter. A data write goes through the data register into whichever RAM is selected. A data read returns the data register, which is then refilled from the next address.

Two RAMs sit behind the counter: a 128-byte display RAM and a 64-byte glyph RAM. An address-set command moves the counter, selects one of the two RAMs, and preloads the data register from the new location. An entry command chooses whether the counter counts up or down after each RAM access.

A controlling state machine sequences the internal work. It has these states:
- IDLE accepts host accesses.
- DECODE applies a command.
- STORE writes the data register to RAM.
- WSTEP moves the counter after a write.
- RSTEP moves the counter after a read.
- LOAD refills the data register.

It moves through these transitions:
- IDLE→DECODE on an accepted command write.
- IDLE→STORE on an accepted data write.
- IDLE→RSTEP on an accepted data read.
- DECODE→LOAD for an address-set command.
- DECODE→IDLE for any other command.
- STORE→WSTEP, then WSTEP→IDLE.
- RSTEP→LOAD, then LOAD→IDLE.

The bus is split into `bus_in`, `bus_out` and an output enable `bus_oe`, which drive the pad-level bidirectional driver outside the block.

Top module: `chd_hostif`

## Requirements
- R1: After reset the busy flag is 0, the address counter is 0, display RAM is selected and the counter direction is increment. A status read then returns 0x00.
- R2: `bus_oe` is 1 only while `host_en` and `host_rd` are both 1. A status read (`host_rs`=0, `host_rd`=1) returns the busy flag on bit 7 and the address counter on bits 6..0.
- R3: Command codes:
  - `1aaaaaaa` sets display RAM address a.
  - `01aaaaaa` sets glyph RAM address a.
  - `000001d0` or `000001d1` sets the counter direction: d=1 counts up, d=0 counts down.
  - Any other code only raises busy and changes neither the counter, the RAM selection nor the direction.
- R4: An accepted data write stores the byte at the counter address of the selected RAM, then steps the counter once.
- R5: An address-set command loads the counter without stepping it and preloads the data register, so the next data read returns the byte at the new address.
- R6: A data read returns the data register, then steps the counter and reloads the data register from the new counter address.
- R7: With direction down, each RAM access decrements the counter by 1.
- R8: The counter wraps modulo 128 for display RAM and modulo 64 for glyph RAM. Bit 6 stays 0 while glyph RAM is selected.
- R9: The busy flag is 1 starting in the cycle after an accepted command or data write, and stays 1 for exactly N_BUSY cycles (N_BUSY ≥ 2).
- R10: A command or data write that arrives while busy is 1 is dropped. It changes no RAM byte, no counter and no mode.
- R11: A data read while busy is 1 returns the data register but neither steps the counter nor reloads the register. An accepted data read holds busy at 1 for the two cycles of its step and reload.
- R12: Display RAM and glyph RAM are separate storage. Writing one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | One-cycle access strobe |
| host_rs | input | 1 | 0 = command/status side, 1 = data side |
| host_rd | input | 1 | 1 = read, 0 = write |
| bus_in | input | 8 | Byte written by the host |
| bus_out | output | 8 | Byte returned to the host (0 when not driving) |
| bus_oe | output | 1 | Enable for the external bus driver |

## Verification
The hardest situation to reach from the ports is a second access landing inside the busy window. The dropped-write and held-read cases only exist for a few cycles after an accepted access. The bench issues back-to-back strobes with no polling in between, in the cycle right after an accepted write or read, so the follow-up access meets a raised busy flag. It then checks the counter and RAM contents through status and data reads to prove nothing moved. Counter wrap in both RAMs is reached by setting the address to the last entry and writing across the boundary.

// File: rtl/chd_pkg.sv
package chd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_STORE,
        ST_WSTEP,
        ST_RSTEP,
        ST_LOAD
    } hif_state_t;

    typedef enum logic [1:0] {
        CMD_DD_ADDR,
        CMD_CG_ADDR,
        CMD_ENTRY,
        CMD_OTHER
    } cmd_kind_t;

    function automatic cmd_kind_t classify_cmd(input logic [7:0] code);
        if (code[7])
            return CMD_DD_ADDR;
        else if (code[7:6] == 2'b01)
            return CMD_CG_ADDR;
        else if (code[7:2] == 6'b000001)
            return CMD_ENTRY;
        else
            return CMD_OTHER;
    endfunction

endpackage

// File: rtl/chd_ram.sv
module chd_ram #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/chd_busy.sv
module chd_busy #(
    parameter int N_BUSY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(N_BUSY + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(N_BUSY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/chd_addr.sv
module chd_addr #(
    parameter int AW    = 7,
    parameter int CG_AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          count_up,
    input  logic          cg_mode,
    output logic [AW-1:0] ac
);
    localparam logic [AW-1:0] CG_MASK = (AW'(1) << CG_AW) - AW'(1);

    logic [AW-1:0] ac_q;
    logic [AW-1:0] nxt;

    always_comb begin
        nxt = count_up ? ac_q + AW'(1) : ac_q - AW'(1);
        if (cg_mode)
            nxt = nxt & CG_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ac_q <= '0;
        else if (load)
            ac_q <= load_val;
        else if (step)
            ac_q <= nxt;
    end

    assign ac = ac_q;

endmodule

// File: rtl/chd_hostif.sv
module chd_hostif #(
    parameter int N_BUSY = 4,
    parameter int DD_AW  = 7,
    parameter int CG_AW  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_en,
    input  logic       host_rs,
    input  logic       host_rd,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe
);
    import chd_pkg::*;

    localparam int AW = 7;
    localparam logic [AW-1:0] CG_MASK = (AW'(1) << CG_AW) - AW'(1);

    hif_state_t state_q, state_d;
    logic [7:0] ir_q, dr_q;
    logic       sel_cg_q, count_up_q;
    logic [AW-1:0] ac;
    logic       busy, timer_busy;
    logic       cmd_acc, data_acc, read_acc;
    cmd_kind_t  kind;

    logic          ac_load, ac_step, dd_we, cg_we, dr_reload, mode_set;
    logic [AW-1:0] ac_load_val;
    logic [7:0]    dd_rdata, cg_rdata;

    assign busy     = timer_busy || (state_q != ST_IDLE);
    assign cmd_acc  = host_en && !host_rd && !host_rs && !busy;
    assign data_acc = host_en && !host_rd &&  host_rs && !busy;
    assign read_acc = host_en &&  host_rd &&  host_rs && !busy;
    assign kind     = classify_cmd(ir_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_acc)
                    state_d = ST_DECODE;
                else if (data_acc)
                    state_d = ST_STORE;
                else if (read_acc)
                    state_d = ST_RSTEP;
            end
            ST_DECODE: begin
                if (kind == CMD_DD_ADDR || kind == CMD_CG_ADDR)
                    state_d = ST_LOAD;
                else
                    state_d = ST_IDLE;
            end
            ST_STORE: state_d = ST_WSTEP;
            ST_WSTEP: state_d = ST_IDLE;
            ST_RSTEP: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        ac_load     = 1'b0;
        ac_load_val = '0;
        ac_step     = 1'b0;
        dd_we       = 1'b0;
        cg_we       = 1'b0;
        dr_reload   = 1'b0;
        mode_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DECODE: begin
                if (kind == CMD_DD_ADDR) begin
                    ac_load     = 1'b1;
                    ac_load_val = ir_q[AW-1:0];
                    mode_set    = 1'b1;
                end else if (kind == CMD_CG_ADDR) begin
                    ac_load     = 1'b1;
                    ac_load_val = ir_q[AW-1:0] & CG_MASK;
                    mode_set    = 1'b1;
                end
            end
            ST_STORE: begin
                dd_we = !sel_cg_q;
                cg_we =  sel_cg_q;
            end
            ST_WSTEP: ac_step   = 1'b1;
            ST_RSTEP: ac_step   = 1'b1;
            ST_LOAD:  dr_reload = 1'b1;
            default: ;
        endcase
    end

    // registers written by the host and by the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q       <= '0;
            dr_q       <= '0;
            sel_cg_q   <= 1'b0;
            count_up_q <= 1'b1;
        end else begin
            if (cmd_acc)
                ir_q <= bus_in;
            if (data_acc)
                dr_q <= bus_in;
            else if (dr_reload)
                dr_q <= sel_cg_q ? cg_rdata : dd_rdata;
            if (mode_set)
                sel_cg_q <= (kind == CMD_CG_ADDR);
            if (state_q == ST_DECODE && kind == CMD_ENTRY)
                count_up_q <= ir_q[1];
        end
    end

    chd_busy #(.N_BUSY(N_BUSY)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cmd_acc || data_acc),
        .active (timer_busy)
    );

    chd_addr #(.AW(AW), .CG_AW(CG_AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ac_load),
        .load_val (ac_load_val),
        .step     (ac_step),
        .count_up (count_up_q),
        .cg_mode  (sel_cg_q),
        .ac       (ac)
    );

    chd_ram #(.AW(DD_AW), .DW(8)) u_dd_ram (
        .clk   (clk),
        .we    (dd_we),
        .addr  (ac[DD_AW-1:0]),
        .wdata (dr_q),
        .rdata (dd_rdata)
    );

    chd_ram #(.AW(CG_AW), .DW(8)) u_cg_ram (
        .clk   (clk),
        .we    (cg_we),
        .addr  (ac[CG_AW-1:0]),
        .wdata (dr_q),
        .rdata (cg_rdata)
    );

    assign bus_oe  = host_en && host_rd;
    assign bus_out = !bus_oe ? 8'h00 : (host_rs ? dr_q : {busy, ac});

endmodule

// File: rtl/chd_hostif_chk.sv
module chd_hostif_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               host_en,
    input logic               host_rs,
    input logic               host_rd,
    input logic               bus_oe,
    input logic               busy,
    input logic               sel_cg,
    input logic [6:0]         ac,
    input chd_pkg::hif_state_t state
);
    import chd_pkg::*;

    // R9: an accepted write raises busy on the next cycle
    a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !host_rd && !busy) |=> busy);

    // R10: a write arriving while busy starts no command or store
    a_r10_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !host_rd && busy) |=> (state != ST_DECODE && state != ST_STORE));

    // R11: an accepted data read keeps busy high for its step
    a_r11_read_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && host_rd && host_rs && !busy) |=> busy);

    // R8: glyph RAM range keeps counter bit 6 clear
    a_r8_cg_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_cg |-> !ac[6]);

    // R4: counter moves only in the decode and step states
    a_r4_ac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_DECODE || state == ST_WSTEP || state == ST_RSTEP) |=> $stable(ac));

    // R2: no bus drive without a read strobe
    a_r2_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_en && host_rd) |-> !bus_oe);

endmodule

bind chd_hostif chd_hostif_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_en (host_en),
    .host_rs (host_rs),
    .host_rd (host_rd),
    .bus_oe  (bus_oe),
    .busy    (busy),
    .sel_cg  (sel_cg_q),
    .ac      (ac),
    .state   (state_q)
);

// File: tb/chd_hostif_test.sv
`timescale 1ns/1ps
module chd_hostif_test;

    localparam int N_BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_en = 1'b0;
    logic       host_rs = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    chd_hostif #(.N_BUSY(N_BUSY)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_en (host_en),
        .host_rs (host_rs),
        .host_rd (host_rd),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit rs, input bit rd, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        host_en = 1'b1;
        host_rs = rs;
        host_rd = rd;
        bus_in  = d;
        #1 q = bus_out;
        @(posedge clk);
        #1 host_en = 1'b0;
    endtask

    task automatic wait_ready();
        logic [7:0] q;
        for (int i = 0; i < 50; i++) begin
            access(1'b0, 1'b1, 8'h00, q);
            if (!q[7]) return;
        end
        check(1'b0, "R9 ready", 1, 0);
    endtask

    task automatic cmd(input logic [7:0] c);
        logic [7:0] q;
        access(1'b0, 1'b0, c, q);
        wait_ready();
    endtask

    task automatic dwrite(input logic [7:0] d);
        logic [7:0] q;
        access(1'b1, 1'b0, d, q);
        wait_ready();
    endtask

    task automatic dread(output logic [7:0] q);
        access(1'b1, 1'b1, 8'h00, q);
        wait_ready();
    endtask

    task automatic status(output logic [7:0] q);
        access(1'b0, 1'b1, 8'h00, q);
    endtask

    task automatic t_reset();
        logic [7:0] q;
        @(negedge clk);
        check(bus_oe == 1'b0, "R2 oe idle", bus_oe, 0);
        status(q);
        check(q == 8'h00, "R1 reset status", q, 8'h00);
    endtask

    task automatic t_busy_width();
        logic [7:0] q;
        int n = 0;
        access(1'b0, 1'b0, 8'h06, q);
        for (int i = 0; i < 20; i++) begin
            status(q);
            if (q[7]) n++;
            else break;
        end
        check(n == N_BUSY, "R9 busy width", n, N_BUSY);
    endtask

    task automatic t_write_read();
        logic [7:0] q;
        cmd(8'h85);
        dwrite(8'hA1);
        dwrite(8'hB2);
        dwrite(8'hC3);
        status(q);
        check(q == 8'h08, "R4 ac after writes", q, 8'h08);
        cmd(8'h85);
        status(q);
        check(q == 8'h05, "R5 no step on set", q, 8'h05);
        dread(q);
        check(q == 8'hA1, "R5 preload", q, 8'hA1);
        dread(q);
        check(q == 8'hB2, "R6 prefetch next", q, 8'hB2);
        status(q);
        check(q == 8'h07, "R6 ac after reads", q, 8'h07);
    endtask

    task automatic t_other_cmd();
        logic [7:0] q;
        cmd(8'h90);
        cmd(8'h01);
        status(q);
        check(q == 8'h10, "R3 other code ac", q, 8'h10);
        dwrite(8'h44);
        status(q);
        check(q == 8'h11, "R3 other code dir", q, 8'h11);
    endtask

    task automatic t_decrement();
        logic [7:0] q;
        cmd(8'h04);
        cmd(8'h8A);
        dwrite(8'h5A);
        dwrite(8'h6B);
        status(q);
        check(q == 8'h08, "R7 ac down", q, 8'h08);
        cmd(8'h06);
        cmd(8'h89);
        dread(q);
        check(q == 8'h6B, "R7 byte at 9", q, 8'h6B);
        dread(q);
        check(q == 8'h5A, "R7 byte at 10", q, 8'h5A);
    endtask

    task automatic t_wrap();
        logic [7:0] q;
        cmd(8'hFF);
        dwrite(8'h77);
        status(q);
        check(q == 8'h00, "R8 display wrap", q, 8'h00);
        dwrite(8'h78);
        cmd(8'hFF);
        dread(q);
        check(q == 8'h77, "R8 display 127", q, 8'h77);
        dread(q);
        check(q == 8'h78, "R8 display 0", q, 8'h78);
        cmd(8'h7F);
        status(q);
        check(q == 8'h3F, "R3 glyph addr set", q, 8'h3F);
        dwrite(8'h1F);
        status(q);
        check(q == 8'h00, "R8 glyph wrap", q, 8'h00);
        dwrite(8'h2E);
        cmd(8'h7F);
        dread(q);
        check(q == 8'h1F, "R8 glyph 63", q, 8'h1F);
        dread(q);
        check(q == 8'h2E, "R8 glyph 0", q, 8'h2E);
        status(q);
        check(q == 8'h01, "R8 glyph ac", q, 8'h01);
        cmd(8'h80);
        dread(q);
        check(q == 8'h78, "R12 display unaffected", q, 8'h78);
    endtask

    task automatic t_drop();
        logic [7:0] q;
        cmd(8'h95);
        dwrite(8'h33);
        cmd(8'h94);
        access(1'b1, 1'b0, 8'h11, q);
        access(1'b1, 1'b0, 8'h22, q);
        access(1'b0, 1'b0, 8'hBC, q);
        wait_ready();
        status(q);
        check(q == 8'h15, "R10 ac unchanged", q, 8'h15);
        cmd(8'h94);
        dread(q);
        check(q == 8'h11, "R10 data kept", q, 8'h11);
        dread(q);
        check(q == 8'h33, "R10 next kept", q, 8'h33);
    endtask

    task automatic t_read_busy();
        logic [7:0] q;
        cmd(8'h94);
        access(1'b1, 1'b1, 8'h00, q);
        check(q == 8'h11, "R11 first read", q, 8'h11);
        access(1'b1, 1'b1, 8'h00, q);
        check(q == 8'h11, "R11 read while busy", q, 8'h11);
        wait_ready();
        status(q);
        check(q == 8'h15, "R11 single step", q, 8'h15);
        dread(q);
        check(q == 8'h33, "R11 reload", q, 8'h33);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_busy_width();
        t_write_read();
        t_other_cmd();
        t_decrement();
        t_wrap();
        t_drop();
        t_read_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule